// File: doc/BRIEF.md
# I2C Audio Control Register Slave

This block is the control front end of a stereo audio processor. It watches the two I2C lines, SCL and SDA, with a fast system clock. It detects start and stop conditions and receives write transfers addressed to it. The block stores a register pointer, called the subaddress. Each data byte then goes into one of five settings: left volume, right volume, bass, treble and a switch-function word. The pointer advances by itself after each data byte, so one transfer can load every setting in turn.

The stored settings drive the analog gain stages as plain parallel codes. Each setting accepts only the codes that map to a real gain step. Any other code is dropped and the old value stays. After reset the outputs are muted, and they stay muted until software writes the switch word with its mute bit clear. The block only receives: it has no reads, no clock stretching and no arbitration.

Top module: `aud_ctl_i2c_slave`

## Requirements
- R1: When SDA falls while SCL is high (a start), the receiver restarts at the address byte. This holds even if it was part way through a byte.
- R2: When SDA rises while SCL is high (a stop), the transfer ends. Bits clocked after a stop and before the next start are not acknowledged and change no setting.
- R3: The first byte is accepted only when bits 7:1 equal the `DEV_ADDR` parameter and bit 0 is 0 (write). Only then does the block acknowledge that byte and the bytes after it. Any other first byte gets no acknowledge, and the rest of that transfer is ignored.
- R4: To acknowledge, `sda_oe` goes high (SDA pulled low) after the SCL falling edge that ends the eighth bit. It goes low again after the SCL falling edge that ends the ninth clock. It never changes while SCL is high.
- R5: The second byte of an accepted transfer is the subaddress. Value 0 selects left volume, 1 right volume, 2 bass, 3 treble and 4 the switch word.
- R6: After each data byte the subaddress goes up by one while it is below 4. At 4 it stays, so further bytes keep rewriting the switch word.
- R7: While the subaddress is above 4 (any value from 5 to 255), data bytes change no setting.
- R8: After reset the outputs are `mute`=1, `sw_cfg`=0, both volumes 6'b111100 (0 dB), and bass and treble 4'b0110 (flat).
- R9: Volume takes data bits 5:0 and ignores bits 7:6. Codes 6'b011011 (attenuation of 80 dB or more) up to 6'b111111 (+6 dB) are stored. Lower codes are dropped.
- R10: Bass and treble take data bits 3:0 and ignore bits 7:4. Bass stores 4'b0010 to 4'b1011. Treble stores 4'b0010 to 4'b1010. Other codes are dropped.
- R11: The switch word takes data bits 5:0 and ignores bits 7:6. Bit 5 drives `mute` (1 = muted) and bits 4:0 drive `sw_cfg`.
- R12: No setting changes while the bus is idle, that is, outside a start-to-stop transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| vol_left | output | VOL_W | Left channel volume code |
| vol_right | output | VOL_W | Right channel volume code |
| bass_code | output | TONE_W | Bass control code |
| treble_code | output | TONE_W | Treble control code |
| sw_cfg | output | SW_W-1 | Switch-function bits other than mute |
| mute | output | 1 | Mute flag, set by reset |

## Verification
The assertions assume that each SCL high and low phase lasts many system clocks beyond the synchronizer depth. They also assume that SDA moves only while SCL is low, except for deliberate start and stop conditions, and that there is a single master that only writes. The stimulus keeps to this. It holds every quarter of an SCL period for 25 system clocks and changes SDA only in the quarter after SCL falls. It releases SDA during every ninth clock, so the acknowledge seen on the bus comes only from the block.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;

   localparam int unsigned REG_COUNT = 5;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);

   typedef enum logic [2:0] {
      SEL_VOL_L  = 3'd0,
      SEL_VOL_R  = 3'd1,
      SEL_BASS   = 3'd2,
      SEL_TREBLE = 3'd3,
      SEL_SWITCH = 3'd4
   } reg_sel_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_SUB,
      PH_DATA
   } phase_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_SHIFT,
      RX_DECIDE,
      RX_ACK_WAIT,
      RX_ACK_DRIVE,
      RX_SKIP
   } rx_state_e;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic sda;
      logic start;
      logic stop;
   } line_ev_t;

endpackage

// File: rtl/aud_line_sync.sv
module aud_line_sync
   import aud_ctl_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_raw,
   input  logic     sda_raw,
   output line_ev_t ev
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_prev;
   logic              sda_prev;
   logic              scl_now;
   logic              sda_now;

   assign scl_now = scl_pipe[STAGES-1];
   assign sda_now = sda_pipe[STAGES-1];

   // idle bus is high, so the pipeline resets high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
         scl_prev <= scl_now;
         sda_prev <= sda_now;
      end
   end

   always_comb begin
      ev.scl_rise = scl_now & ~scl_prev;
      ev.scl_fall = ~scl_now & scl_prev;
      ev.sda      = sda_now;
      ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
      ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
   end

endmodule

// File: rtl/aud_byte_rx.sv
module aud_byte_rx
   import aud_ctl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h44
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_ev_t          ev,
   output logic              busy,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_sel,
   output logic [BYTE_W-1:0] wr_data
);

   localparam logic [BYTE_W-1:0]    LAST_SEL = BYTE_W'(REG_COUNT - 1);
   localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

   rx_state_e            state_q;
   phase_e               phase_q;
   logic [BIT_CNT_W-1:0] bit_cnt_q;
   logic [BYTE_W-1:0]    shift_q;
   logic [BYTE_W-1:0]    sub_q;
   logic                 ack_q;
   logic                 oe_q;
   logic                 busy_q;
   logic                 addr_hit;

   assign addr_hit = (shift_q[BYTE_W-1:1] == DEV_ADDR) && !shift_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_IDLE;
         phase_q   <= PH_ADDR;
         bit_cnt_q <= '0;
         shift_q   <= '0;
         sub_q     <= '0;
         ack_q     <= 1'b0;
         oe_q      <= 1'b0;
         busy_q    <= 1'b0;
      end else if (ev.start) begin
         state_q   <= RX_SHIFT;
         phase_q   <= PH_ADDR;
         bit_cnt_q <= '0;
         oe_q      <= 1'b0;
         busy_q    <= 1'b1;
      end else if (ev.stop) begin
         state_q <= RX_IDLE;
         oe_q    <= 1'b0;
         busy_q  <= 1'b0;
      end else begin
         unique case (state_q)
            RX_SHIFT: begin
               if (ev.scl_rise) begin
                  shift_q   <= {shift_q[BYTE_W-2:0], ev.sda};
                  bit_cnt_q <= bit_cnt_q + 1'b1;
                  if (bit_cnt_q == LAST_BIT) begin
                     state_q <= RX_DECIDE;
                  end
               end
            end
            RX_DECIDE: begin
               state_q <= RX_ACK_WAIT;
               unique case (phase_q)
                  PH_ADDR: begin
                     ack_q <= addr_hit;
                     if (addr_hit) begin
                        phase_q <= PH_SUB;
                     end
                  end
                  PH_SUB: begin
                     ack_q   <= 1'b1;
                     sub_q   <= shift_q;
                     phase_q <= PH_DATA;
                  end
                  default: begin
                     ack_q <= 1'b1;
                     if (sub_q < LAST_SEL) begin
                        sub_q <= sub_q + 1'b1;
                     end
                  end
               endcase
            end
            RX_ACK_WAIT: begin
               if (ev.scl_fall) begin
                  if (ack_q) begin
                     oe_q    <= 1'b1;
                     state_q <= RX_ACK_DRIVE;
                  end else begin
                     state_q <= RX_SKIP;
                  end
               end
            end
            RX_ACK_DRIVE: begin
               if (ev.scl_fall) begin
                  oe_q    <= 1'b0;
                  state_q <= RX_SHIFT;
               end
            end
            default: begin
            end
         endcase
      end
   end

   assign wr_en   = (state_q == RX_DECIDE) && (phase_q == PH_DATA);
   assign wr_sel  = sub_q;
   assign wr_data = shift_q;
   assign sda_oe  = oe_q;
   assign busy    = busy_q;

endmodule

// File: rtl/aud_ctl_regs.sv
module aud_ctl_regs
   import aud_ctl_pkg::*;
#(
   parameter int unsigned VOL_W      = 6,
   parameter int unsigned TONE_W     = 4,
   parameter int unsigned SW_W       = 6,
   parameter int unsigned VOL_MIN    = 27,
   parameter int unsigned VOL_RESET  = 60,
   parameter int unsigned TONE_MIN   = 2,
   parameter int unsigned TONE_FLAT  = 6,
   parameter int unsigned BASS_MAX   = 11,
   parameter int unsigned TREBLE_MAX = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [VOL_W-1:0]  vol_l,
   output logic [VOL_W-1:0]  vol_r,
   output logic [TONE_W-1:0] bass,
   output logic [TONE_W-1:0] treble,
   output logic [SW_W-1:0]   sw
);

   function automatic int unsigned fld_width(input int unsigned idx);
      case (idx)
         0, 1:    return VOL_W;
         2, 3:    return TONE_W;
         default: return SW_W;
      endcase
   endfunction

   function automatic int unsigned fld_lo(input int unsigned idx);
      case (idx)
         0, 1:    return VOL_MIN;
         2, 3:    return TONE_MIN;
         default: return 0;
      endcase
   endfunction

   function automatic int unsigned fld_hi(input int unsigned idx);
      case (idx)
         0, 1:    return (1 << VOL_W) - 1;
         2:       return BASS_MAX;
         3:       return TREBLE_MAX;
         default: return (1 << SW_W) - 1;
      endcase
   endfunction

   function automatic int unsigned fld_reset(input int unsigned idx);
      case (idx)
         0, 1:    return VOL_RESET;
         2, 3:    return TONE_FLAT;
         default: return 1 << (SW_W - 1);
      endcase
   endfunction

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
      localparam int unsigned W     = fld_width(g);
      localparam int unsigned LO    = fld_lo(g);
      localparam int unsigned HI    = fld_hi(g);
      localparam int unsigned MAXV  = (1 << W) - 1;
      localparam logic [W-1:0] RSTV = W'(fld_reset(g));

      logic [W-1:0] q;
      logic [W-1:0] field;
      logic         lo_ok;
      logic         hi_ok;
      logic         hit;

      assign field = wr_data[W-1:0];

      // bounds only exist where the legal range is narrower than the field
      if (LO > 0) begin : g_lo
         assign lo_ok = 32'(field) >= LO;
      end else begin : g_lo_any
         assign lo_ok = 1'b1;
      end

      if (HI < MAXV) begin : g_hi
         assign hi_ok = 32'(field) <= HI;
      end else begin : g_hi_any
         assign hi_ok = 1'b1;
      end

      assign hit = wr_en && (wr_sel == BYTE_W'(g)) && lo_ok && hi_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RSTV;
         end else if (hit) begin
            q <= field;
         end
      end

      case (g)
         0:       begin : g_out_vl assign vol_l  = q; end
         1:       begin : g_out_vr assign vol_r  = q; end
         2:       begin : g_out_bs assign bass   = q; end
         3:       begin : g_out_tr assign treble = q; end
         default: begin : g_out_sw assign sw     = q; end
      endcase
   end

endmodule

// File: rtl/aud_ctl_i2c_slave.sv
module aud_ctl_i2c_slave
   import aud_ctl_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR    = 7'h44,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned VOL_W       = 6,
   parameter int unsigned TONE_W      = 4,
   parameter int unsigned SW_W        = 6,
   parameter int unsigned VOL_MIN     = 27,
   parameter int unsigned VOL_RESET   = 60,
   parameter int unsigned TONE_MIN    = 2,
   parameter int unsigned TONE_FLAT   = 6,
   parameter int unsigned BASS_MAX    = 11,
   parameter int unsigned TREBLE_MAX  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [VOL_W-1:0]  vol_left,
   output logic [VOL_W-1:0]  vol_right,
   output logic [TONE_W-1:0] bass_code,
   output logic [TONE_W-1:0] treble_code,
   output logic [SW_W-2:0]   sw_cfg,
   output logic              mute
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("aud_ctl_i2c_slave: SYNC_STAGES below 2");
   end
   if (VOL_W < 1 || VOL_W > BYTE_W) begin : g_bad_vol_w
      $error("aud_ctl_i2c_slave: VOL_W out of range");
   end
   if (TONE_W < 1 || TONE_W > BYTE_W) begin : g_bad_tone_w
      $error("aud_ctl_i2c_slave: TONE_W out of range");
   end
   if (SW_W < 2 || SW_W > BYTE_W) begin : g_bad_sw_w
      $error("aud_ctl_i2c_slave: SW_W out of range");
   end
   if (VOL_MIN > VOL_RESET || VOL_RESET >= (1 << VOL_W)) begin : g_bad_vol
      $error("aud_ctl_i2c_slave: volume limits inconsistent");
   end
   if (TONE_FLAT < TONE_MIN || TONE_FLAT > TREBLE_MAX || TONE_FLAT > BASS_MAX
       || BASS_MAX >= (1 << TONE_W) || TREBLE_MAX >= (1 << TONE_W)) begin : g_bad_tone
      $error("aud_ctl_i2c_slave: tone limits inconsistent");
   end

   line_ev_t          line_ev;
   logic              bus_busy;
   logic              wr_en;
   logic [BYTE_W-1:0] wr_sel;
   logic [BYTE_W-1:0] wr_data;
   logic [SW_W-1:0]   sw_word;

   aud_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_raw (scl_i),
      .sda_raw (sda_i),
      .ev      (line_ev)
   );

   aud_byte_rx #(
      .DEV_ADDR (DEV_ADDR)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (line_ev),
      .busy    (bus_busy),
      .sda_oe  (sda_oe),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data)
   );

   aud_ctl_regs #(
      .VOL_W      (VOL_W),
      .TONE_W     (TONE_W),
      .SW_W       (SW_W),
      .VOL_MIN    (VOL_MIN),
      .VOL_RESET  (VOL_RESET),
      .TONE_MIN   (TONE_MIN),
      .TONE_FLAT  (TONE_FLAT),
      .BASS_MAX   (BASS_MAX),
      .TREBLE_MAX (TREBLE_MAX)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .vol_l   (vol_left),
      .vol_r   (vol_right),
      .bass    (bass_code),
      .treble  (treble_code),
      .sw      (sw_word)
   );

   assign mute   = sw_word[SW_W-1];
   assign sw_cfg = sw_word[SW_W-2:0];

endmodule

// File: rtl/aud_ctl_chk.sv
module aud_ctl_chk #(
   parameter int unsigned VOL_W      = 6,
   parameter int unsigned TONE_W     = 4,
   parameter int unsigned SW_W       = 6,
   parameter int unsigned VOL_MIN    = 27,
   parameter int unsigned VOL_RESET  = 60,
   parameter int unsigned TONE_MIN   = 2,
   parameter int unsigned BASS_MAX   = 11,
   parameter int unsigned TREBLE_MAX = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic              busy,
   input logic [VOL_W-1:0]  vol_left,
   input logic [VOL_W-1:0]  vol_right,
   input logic [TONE_W-1:0] bass_code,
   input logic [TONE_W-1:0] treble_code,
   input logic [SW_W-2:0]   sw_cfg,
   input logic              mute
);

   localparam logic [VOL_W-1:0]  VOL_MIN_C = VOL_W'(VOL_MIN);
   localparam logic [VOL_W-1:0]  VOL_RST_C = VOL_W'(VOL_RESET);
   localparam logic [TONE_W-1:0] TONE_LO_C = TONE_W'(TONE_MIN);
   localparam logic [TONE_W-1:0] BASS_HI_C = TONE_W'(BASS_MAX);
   localparam logic [TONE_W-1:0] TREB_HI_C = TONE_W'(TREBLE_MAX);

   assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mute && vol_left == VOL_RST_C && vol_right == VOL_RST_C));

   assert_vol_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vol_left >= VOL_MIN_C) && (vol_right >= VOL_MIN_C));

   assert_tone_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bass_code >= TONE_LO_C) && (bass_code <= BASS_HI_C)
      && (treble_code >= TONE_LO_C) && (treble_code <= TREB_HI_C));

   assert_ack_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   assert_ack_in_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> busy);

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable({vol_left, vol_right, bass_code, treble_code, sw_cfg, mute}));

endmodule

bind aud_ctl_i2c_slave aud_ctl_chk #(
   .VOL_W      (VOL_W),
   .TONE_W     (TONE_W),
   .SW_W       (SW_W),
   .VOL_MIN    (VOL_MIN),
   .VOL_RESET  (VOL_RESET),
   .TONE_MIN   (TONE_MIN),
   .BASS_MAX   (BASS_MAX),
   .TREBLE_MAX (TREBLE_MAX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_i       (scl_i),
   .sda_oe      (sda_oe),
   .busy        (bus_busy),
   .vol_left    (vol_left),
   .vol_right   (vol_right),
   .bass_code   (bass_code),
   .treble_code (treble_code),
   .sw_cfg      (sw_cfg),
   .mute        (mute)
);

// File: tb/tb_aud_ctl_i2c_slave.sv
module tb_aud_ctl_i2c_slave;

   localparam logic [6:0] DEV = 7'h44;
   localparam int Q = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_oe;
   logic [5:0] vol_left, vol_right;
   logic [3:0] bass_code, treble_code;
   logic [4:0] sw_cfg;
   logic mute;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;

   aud_ctl_i2c_slave #(.DEV_ADDR(DEV)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_bus),
      .sda_oe      (sda_oe),
      .vol_left    (vol_left),
      .vol_right   (vol_right),
      .bass_code   (bass_code),
      .treble_code (treble_code),
      .sw_cfg      (sw_cfg),
      .mute        (mute)
   );

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      string      tag;
      logic [5:0] vl;
      logic [5:0] vr;
      logic [3:0] bs;
      logic [3:0] tr;
      logic [4:0] cfg;
      logic       mu;
   } snap_t;

   snap_t      exp_q[$];
   event       snap_ev;
   logic [7:0] txq[$];

   logic [5:0] m_vl, m_vr;
   logic [3:0] m_bs, m_tr;
   logic [4:0] m_cfg;
   logic       m_mu;
   logic [7:0] m_sub;

   task automatic model_reset();
      m_vl = 6'b111100; m_vr = 6'b111100;
      m_bs = 4'b0110;   m_tr = 4'b0110;
      m_cfg = 5'd0;     m_mu = 1'b1;
      m_sub = 8'd0;
   endtask

   task automatic model_data(input logic [7:0] d);
      case (m_sub)
         8'd0: if (d[5:0] >= 6'b011011) m_vl = d[5:0];
         8'd1: if (d[5:0] >= 6'b011011) m_vr = d[5:0];
         8'd2: if (d[3:0] >= 4'd2 && d[3:0] <= 4'd11) m_bs = d[3:0];
         8'd3: if (d[3:0] >= 4'd2 && d[3:0] <= 4'd10) m_tr = d[3:0];
         8'd4: begin m_mu = d[5]; m_cfg = d[4:0]; end
         default: ;
      endcase
      if (m_sub < 8'd4) m_sub = m_sub + 8'd1;
   endtask

   task automatic push_snap(input string tag);
      snap_t s;
      s.tag = tag; s.vl = m_vl; s.vr = m_vr; s.bs = m_bs;
      s.tr = m_tr; s.cfg = m_cfg; s.mu = m_mu;
      exp_q.push_back(s);
      ->snap_ev;
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // monitor: compares the outputs with each expected snapshot
   initial begin
      snap_t e;
      forever begin
         @(snap_ev);
         while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_chk++;
            if (vol_left !== e.vl || vol_right !== e.vr || bass_code !== e.bs ||
                treble_code !== e.tr || sw_cfg !== e.cfg || mute !== e.mu) begin
               n_err++;
               $display("FAIL %s: got vl=%h vr=%h bass=%h treble=%h cfg=%h mute=%b expected vl=%h vr=%h bass=%h treble=%h cfg=%h mute=%b",
                        e.tag, vol_left, vol_right, bass_code, treble_code, sw_cfg, mute,
                        e.vl, e.vr, e.bs, e.tr, e.cfg, e.mu);
            end
         end
      end
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wq();
      scl = 1'b1;   wq();
      sda_m = 1'b0; wq();
      scl = 1'b0;   wq();
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wq();
      scl = 1'b1;   wq();
      sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;  wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wq();
      scl = 1'b1;   wq();
      ack = ~sda_bus; wq();
      scl = 1'b0;   wq();
      check_bit("R4 release after ninth clock", sda_oe, 1'b0);
   endtask

   task automatic xfer(input logic [7:0] abyte, input string tag);
      logic ack;
      logic match;
      logic first;
      match = (abyte == {DEV, 1'b0});
      i2c_start();
      send_byte(abyte, ack);
      check_bit({tag, " R3 address ack"}, ack, match);
      first = 1'b1;
      foreach (txq[i]) begin
         send_byte(txq[i], ack);
         check_bit({tag, " R4 byte ack"}, ack, match);
         if (match) begin
            if (first) m_sub = txq[i];
            else model_data(txq[i]);
         end
         first = 1'b0;
      end
      i2c_stop();
      txq.delete();
      wq();
      push_snap(tag);
   endtask

   initial begin
      logic ack;
      model_reset();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wq();
      push_snap("R8 reset state");
      check_bit("R8 sda_oe at reset", sda_oe, 1'b0);

      // R5 R6 R11: full load from subaddress 0, unmute
      txq = '{8'h00, 8'h3F, 8'h1C, 8'h0B, 8'h02, 8'h00};
      xfer({DEV, 1'b0}, "R5/R6/R11 full load");

      // R6: pointer stops at the switch word
      txq = '{8'h03, 8'h0A, 8'h25, 8'h03};
      xfer({DEV, 1'b0}, "R6 saturate at switch");

      // R9 R10 R11: illegal codes dropped, upper bits ignored
      txq = '{8'h00, 8'h1A, 8'hDB, 8'h0C, 8'h0B, 8'hC8};
      xfer({DEV, 1'b0}, "R9/R10/R11 code limits");

      // R10: upper nibble ignored, illegal treble dropped
      txq = '{8'h02, 8'h57, 8'hF1};
      xfer({DEV, 1'b0}, "R10 tone nibble");

      // R7: subaddress beyond the last register
      txq = '{8'h05, 8'h3F, 8'h0C};
      xfer({DEV, 1'b0}, "R7 subaddress 5");
      txq = '{8'hFF, 8'h00};
      xfer({DEV, 1'b0}, "R7 subaddress 255");

      // R3: wrong address and read bit
      txq = '{8'h00, 8'h3F};
      xfer({DEV ^ 7'h01, 1'b0}, "R3 wrong address");
      xfer({DEV, 1'b1}, "R3 read bit");

      // R1: start in the middle of a byte restarts the receiver
      i2c_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      txq = '{8'h01, 8'h30};
      xfer({DEV, 1'b0}, "R1 restart mid byte");

      // R2 R12: bits after a stop without a new start
      send_byte({DEV, 1'b0}, ack);
      check_bit("R2 no ack after stop", ack, 1'b0);
      send_byte(8'h00, ack);
      check_bit("R2 no ack after stop", ack, 1'b0);
      send_byte(8'h3F, ack);
      check_bit("R12 no ack while idle", ack, 1'b0);
      scl = 1'b1; wq();
      push_snap("R2/R12 idle bits ignored");

      // R8: reset again mid run
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      wq();
      push_snap("R8 reset after writes");

      wq();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule